// File: doc/BRIEF.md
# Enable-Driven Bit Compaction Unit

This block packs a run-time-selected, possibly sparse subset of a 32-bit data word into a dense 16-bit result. A 32-bit enable word marks which data bits are wanted. The wanted bits are placed side by side starting at output bit 0. They keep their relative order, so the lowest enabled index lands lowest. Output positions that receive no bit read as zero. When more than 16 enables are set, only the first 16 in ascending index order are kept.

The selection is worked out combinationally from the present inputs. The result is captured in a single output register on the rising clock edge, so it appears one clock after the inputs. A synchronous, active-high reset clears that register. The block has no handshake: it captures on every clock and presents a new result on every clock.

Top module: `bcmp_top`

## Requirements
- R1: Data bits are taken in ascending index order; the k-th enabled data bit, counting from zero, appears at output bit k.
- R2: Once 16 bits have been placed, every further enabled data bit is dropped and has no effect on the output.
- R3: When n < 16 enables are set, output bits n through 15 are 0.
- R4: The output register loads on the rising clock edge. A change on either input shows at the output exactly one clock later and not before. With inputs held, the output holds.
- R5: A synchronous active-high reset drives the output to 16'h0000 on the next rising edge, whatever the inputs are.
- R6: With the enable word all zeros, the output is 16'h0000 after the next rising edge.
- R7: A data bit whose enable is 0 has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 32 | Data word to compact |
| den | input | 32 | Per-bit enable word, 1 selects the matching data bit |
| dout | output | 16 | Registered compacted result |

## Verification
Reset and a fresh capture can fall in the same cycle. The bench provokes this by holding reset high while the inputs would produce a non-zero result. It judges the outcome by requiring 16'h0000 after that edge, then the compacted value one edge after reset falls. Truncation and zero filling can also meet in one result. Vectors with exactly 16 enables, with 17 or more, and with fewer than 16 are compared against values worked out by hand.

// File: rtl/bcmp_pkg.sv
package bcmp_pkg;
  localparam int unsigned BCMP_IN_W  = 32;
  localparam int unsigned BCMP_OUT_W = 16;
endpackage

// File: rtl/bcmp_rank.sv
// Prefix count: for every input bit, how many enables are set below it.
module bcmp_rank #(
  parameter int unsigned IN_W  = 32,
  parameter int unsigned CNT_W = $clog2(IN_W + 1)
) (
  input  logic [IN_W-1:0]  en,
  output logic [CNT_W-1:0] rank [IN_W]
);
  assign rank[0] = '0;
  for (genvar i = 1; i < IN_W; i++) begin : g_pfx
    assign rank[i] = rank[i-1] + CNT_W'(en[i-1]);
  end
endmodule

// File: rtl/bcmp_gather.sv
// Each output slot ORs in the single enabled data bit whose rank equals it.
// Ranks of OUT_W or more match no slot, which truncates the result.
module bcmp_gather #(
  parameter int unsigned IN_W  = 32,
  parameter int unsigned OUT_W = 16,
  parameter int unsigned CNT_W = $clog2(IN_W + 1)
) (
  input  logic [IN_W-1:0]  data,
  input  logic [IN_W-1:0]  en,
  input  logic [CNT_W-1:0] rank [IN_W],
  output logic [OUT_W-1:0] packed_o
);
  for (genvar k = 0; k < OUT_W; k++) begin : g_slot
    logic [IN_W-1:0] hit;
    for (genvar i = 0; i < IN_W; i++) begin : g_src
      assign hit[i] = data[i] & en[i] & (rank[i] == CNT_W'(k));
    end
    assign packed_o[k] = |hit;
  end
endmodule

// File: rtl/bcmp_top.sv
module bcmp_top
  import bcmp_pkg::*;
#(
  parameter int unsigned IN_W  = BCMP_IN_W,
  parameter int unsigned OUT_W = BCMP_OUT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IN_W-1:0]  din,
  input  logic [IN_W-1:0]  den,
  output logic [OUT_W-1:0] dout
);
  localparam int unsigned CNT_W = $clog2(IN_W + 1);

  logic [CNT_W-1:0] rank [IN_W];
  logic [OUT_W-1:0] packed_c;

  bcmp_rank #(.IN_W(IN_W), .CNT_W(CNT_W)) u_rank (
    .en   (den),
    .rank (rank)
  );

  bcmp_gather #(.IN_W(IN_W), .OUT_W(OUT_W), .CNT_W(CNT_W)) u_gather (
    .data     (din),
    .en       (den),
    .rank     (rank),
    .packed_o (packed_c)
  );

  always_ff @(posedge clk) begin
    if (rst) dout <= '0;
    else     dout <= packed_c;
  end
endmodule

// File: rtl/bcmp_chk.sv
module bcmp_chk #(
  parameter int unsigned IN_W  = 32,
  parameter int unsigned OUT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [IN_W-1:0]  din,
  input logic [IN_W-1:0]  den,
  input logic [OUT_W-1:0] dout
);
  // R5
  a_r5_reset_clears: assert property (@(posedge clk) rst |=> (dout == '0));

  // R6
  a_r6_no_enables: assert property (@(posedge clk) disable iff (rst)
    (den == '0) |=> (dout == '0));

  // R1: lowest data bit lands at slot 0 when enabled
  a_r1_bit0_first: assert property (@(posedge clk) disable iff (rst)
    den[0] |=> (dout[0] == $past(din[0])));

  // R3
  a_r3_zero_fill: assert property (@(posedge clk) disable iff (rst)
    ($countones(den) < OUT_W) |=> ((dout >> $past($countones(den))) == '0));

  // R2: low OUT_W enables all set, so higher enabled bits must be dropped
  a_r2_truncate: assert property (@(posedge clk) disable iff (rst)
    (den[OUT_W-1:0] == '1) |=> (dout == $past(din[OUT_W-1:0])));

  // R4
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    ($stable(din) && $stable(den) && !$past(rst)) |=> $stable(dout));
endmodule

bind bcmp_top bcmp_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) u_bcmp_chk (
  .clk  (clk),
  .rst  (rst),
  .din  (din),
  .den  (den),
  .dout (dout)
);

// File: tb/tb_bcmp_top.sv
module tb_bcmp_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 5000;
  localparam int NVEC       = 10;

  // {din, den, expected}
  localparam logic [79:0] VEC [NVEC] = '{
    {32'hFFFFFFFF, 32'h00000000, 16'h0000},  // R6 no enables
    {32'hFFFFFFFF, 32'h0000000F, 16'h000F},  // R3 four bits, rest zero
    {32'hAAAAAAAA, 32'hFFFFFFFF, 16'hAAAA},  // R2 first 16 kept
    {32'h0000FFFF, 32'hFFFF0000, 16'h0000},  // R1 upper half gathered
    {32'h12345678, 32'h0000FFFF, 16'h5678},  // R1 dense low half
    {32'hFFFF0000, 32'h80000001, 16'h0002},  // R1 widely spaced
    {32'hFFFF0000, 32'hAAAAAAAA, 16'hFF00},  // R1 odd indices
    {32'hFFFFFFFE, 32'h00000001, 16'h0000},  // R7 disabled ones ignored
    {32'h80000000, 32'hFFFF8000, 16'h0000},  // R2 17th enabled bit dropped
    {32'hFFFFFFFF, 32'h00010101, 16'h0007}   // R3 three bits
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] din = '0;
  logic [31:0] den = '0;
  logic [15:0] dout;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  bcmp_top dut (.clk(clk), .rst(rst), .din(din), .den(den), .dout(dout));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: dout=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: dout=%h expected=finish", dout);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick();
    check("R5 reset state", dout, 16'h0000);
    rst = 1'b0;

    for (int v = 0; v < NVEC; v++) begin
      din = VEC[v][79:48];
      den = VEC[v][47:16];
      tick();
      check($sformatf("R1/R2/R3/R6/R7 vector %0d", v), dout, VEC[v][15:0]);
    end

    // R4: one clock latency and hold
    din = 32'h0000FFFF; den = 32'h0000FFFF;
    tick();
    check("R4 load", dout, 16'hFFFF);
    din = 32'h00000000;
    #1;
    check("R4 no early change", dout, 16'hFFFF);
    tick();
    check("R4 change after one edge", dout, 16'h0000);
    din = 32'h000000F0; den = 32'h000000F0;
    tick();
    tick();
    check("R4 held inputs hold output", dout, 16'h000F);

    // R5: reset wins over a nonzero capture in the same cycle
    rst = 1'b1; din = 32'hFFFFFFFF; den = 32'hFFFFFFFF;
    tick();
    check("R5 reset beats capture", dout, 16'h0000);
    rst = 1'b0;
    tick();
    check("R5 capture after reset release", dout, 16'hFFFF);

    // R7: toggling disabled data bits changes nothing
    din = 32'h00000003; den = 32'h00000003;
    tick();
    check("R7 baseline", dout, 16'h0003);
    din = 32'hFFFFFFFF;
    tick();
    check("R7 disabled bits toggled", dout, 16'h0003);

    // R2: exactly 16 enabled at the top, then a 17th added below
    din = 32'hFFFF0000; den = 32'hFFFF0000;
    tick();
    check("R2 exactly sixteen", dout, 16'hFFFF);
    den = 32'hFFFF0001;
    tick();
    check("R2 seventeenth dropped", dout, 16'hFFFE);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule